// File: doc/BRIEF.md
# Program Operation Status Reporter

This block sits on the host read path of a flash-style memory and tells the host how an internal word-program operation is going. It watches the host bus strobes and keeps the address and data of the most recent bus write: the address at the moment both chip-enable and write-enable are low, and the data at the moment either strobe goes high again. When the program engine signals a start, the block copies that address and data into a target register. It presents the target to the engine and drops its ready output.

While the operation runs, host reads get a status word instead of array contents. Bit 7 is the inverse of the target's bit 7. Bit 6 flips on every accepted read. Bit 5 flags an exceeded timing limit. When the engine reports completion, the block releases the target and returns to plain array reads, so the first read after completion already shows the true data. A timing-limit failure holds the status view until a reset command clears it. A hardware reset aborts everything at once.

Reads use a valid/ready request channel and a valid/ready response channel. A request is accepted when `rd_valid` and `rd_ready` are both high. `rd_ready` is high whenever the response slot is empty or is being drained in the same cycle. A response stays valid and unchanged until `rsp_ready` takes it. The array word for an accepted read must be on `arr_rdata` in the accepting cycle.

Top module: `prog_status_rep`

## Requirements
- R1: The block keeps `bus_addr` from the first clock in which `ce_n` and `we_n` are both low after either was high. Later address changes inside that window have no effect.
- R2: The block keeps `bus_wdata` from the first clock in which either strobe is high after both were low.
- R3: A `pgm_start` pulse while ready loads the kept address and data into `tgt_addr`/`tgt_data`. From the next cycle it drives `tgt_vld` high and `ready_o` low, and `tgt_vld` stays high for as long as `ready_o` is low.
- R4: A read accepted while busy returns bit 7 equal to the inverse of `tgt_data[7]`.
- R5: Bit 6 of a busy read is 0 on the first read after a start and flips on each further accepted read.
- R6: During a normal busy period bit 5 reads 0. In every status word, all bits other than 7, 6 and 5 read 0.
- R7: `pgm_done` while busy, with no timeout, returns the block to ready with `tgt_vld` low in the next cycle. Reads accepted from then on return `arr_rdata`.
- R8: `pgm_timeout` while busy moves the block to a failed state. This holds even if `pgm_done` is high in the same cycle. In the failed state bit 5 reads 1, bits 7 and 6 behave as in R4 and R5, `ready_o` stays low, and `pgm_done` has no effect.
- R9: `clr_cmd` in the failed state returns the block to ready and drops `tgt_vld`. `clr_cmd` during a normal busy period has no effect.
- R10: A low `rst_n` aborts any operation. After reset the block is ready, `tgt_vld` is low and no response is pending.
- R11: A response held with `rsp_ready` low keeps `rsp_valid` high and `rsp_data` stable, and `rd_ready` stays low until the response is taken.
- R12: `pgm_start` while not ready has no effect on the target or on the bit 6 sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| ce_n | input | 1 | Host chip-enable, active low |
| we_n | input | 1 | Host write-enable, active low |
| bus_addr | input | ADDR_W | Host bus address |
| bus_wdata | input | DATA_W | Host bus write data |
| pgm_start | input | 1 | Engine starts a program operation |
| pgm_done | input | 1 | Engine finished successfully |
| pgm_timeout | input | 1 | Engine exceeded its timing limit |
| clr_cmd | input | 1 | Decoded reset command |
| tgt_addr | output | ADDR_W | Address being programmed |
| tgt_data | output | DATA_W | Data being programmed |
| tgt_vld | output | 1 | Target register holds an active operation |
| ready_o | output | 1 | High when no operation is running or failed |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request accepted this cycle |
| arr_rdata | input | DATA_W | Array word for the requested address |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Host takes the response |
| rsp_data | output | DATA_W | Array word or status word |

## Verification
The bench builds the block with ADDR_W = 4 and DATA_W = 16. The narrow address lets a 16-word array model back every read. The 16-bit word leaves an upper byte that must read zero in status words while it carries array data in read mode. Written data is chosen with bit 7 both set and clear, so both polarities of the poll bit are seen. Timeout, completion, reset command and hardware reset are each applied in the busy and failed states, and the response channel is stalled so that the back-pressure rules are exercised.

// File: rtl/prog_status_pkg.sv
package prog_status_pkg;

  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_BUSY = 2'd1,
    PS_FAIL = 2'd2
  } ps_state_e;

  localparam int POLL_POS = 7;
  localparam int FLIP_POS = 6;
  localparam int TERR_POS = 5;

endpackage

// File: rtl/psr_bus_capture.sv
module psr_bus_capture #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [DATA_W-1:0] cap_data
);

  logic win, win_q;

  // a write window is open only while both strobes are low
  assign win = ~ce_n & ~we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q    <= 1'b0;
      cap_addr <= '0;
      cap_data <= '0;
    end else begin
      win_q <= win;
      if (win && !win_q) cap_addr <= bus_addr;
      if (!win && win_q) cap_data <= bus_wdata;
    end
  end

endmodule

// File: rtl/psr_op_tracker.sv
module psr_op_tracker
  import prog_status_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pgm_start,
  input  logic              pgm_done,
  input  logic              pgm_timeout,
  input  logic              clr_cmd,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [DATA_W-1:0] cap_data,
  output ps_state_e         state,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [DATA_W-1:0] tgt_data,
  output logic              tgt_vld,
  output logic              start_fire
);

  assign start_fire = (state == PS_IDLE) && pgm_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= PS_IDLE;
      tgt_addr <= '0;
      tgt_data <= '0;
      tgt_vld  <= 1'b0;
    end else begin
      unique case (state)
        PS_IDLE: begin
          if (pgm_start) begin
            state    <= PS_BUSY;
            tgt_addr <= cap_addr;
            tgt_data <= cap_data;
            tgt_vld  <= 1'b1;
          end
        end
        PS_BUSY: begin
          if (pgm_timeout) begin
            state <= PS_FAIL;
          end else if (pgm_done) begin
            state    <= PS_IDLE;
            tgt_addr <= '0;
            tgt_data <= '0;
            tgt_vld  <= 1'b0;
          end
        end
        PS_FAIL: begin
          if (clr_cmd) begin
            state    <= PS_IDLE;
            tgt_addr <= '0;
            tgt_data <= '0;
            tgt_vld  <= 1'b0;
          end
        end
        default: state <= PS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/psr_read_resp.sv
module psr_read_resp
  import prog_status_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ps_state_e         state,
  input  logic              poll_src,
  input  logic              start_fire,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data
);

  logic              flip_q;
  logic              accept;
  logic [DATA_W-1:0] stat_word;

  assign rd_ready = ~rsp_valid | rsp_ready;
  assign accept   = rd_valid & rd_ready;

  always_comb begin
    stat_word           = '0;
    stat_word[POLL_POS] = ~poll_src;
    stat_word[FLIP_POS] = flip_q;
    stat_word[TERR_POS] = (state == PS_FAIL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flip_q <= 1'b0;
    end else if (start_fire) begin
      flip_q <= 1'b0;
    end else if (accept && state != PS_IDLE) begin
      flip_q <= ~flip_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_data  <= (state == PS_IDLE) ? arr_rdata : stat_word;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/prog_status_rep.sv
module prog_status_rep
  import prog_status_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              pgm_start,
  input  logic              pgm_done,
  input  logic              pgm_timeout,
  input  logic              clr_cmd,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [DATA_W-1:0] tgt_data,
  output logic              tgt_vld,
  output logic              ready_o,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data
);

  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_data;
  ps_state_e         op_state;
  logic              start_fire;

  psr_bus_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) cap_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .cap_addr(cap_addr), .cap_data(cap_data)
  );

  psr_op_tracker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) trk_i (
    .clk(clk), .rst_n(rst_n),
    .pgm_start(pgm_start), .pgm_done(pgm_done),
    .pgm_timeout(pgm_timeout), .clr_cmd(clr_cmd),
    .cap_addr(cap_addr), .cap_data(cap_data),
    .state(op_state), .tgt_addr(tgt_addr), .tgt_data(tgt_data),
    .tgt_vld(tgt_vld), .start_fire(start_fire)
  );

  psr_read_resp #(.DATA_W(DATA_W)) rsp_i (
    .clk(clk), .rst_n(rst_n), .state(op_state),
    .poll_src(tgt_data[POLL_POS]), .start_fire(start_fire),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .arr_rdata(arr_rdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  assign ready_o = (op_state == PS_IDLE);

endmodule

// File: rtl/prog_status_rep_chk.sv
module prog_status_rep_chk
  import prog_status_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pgm_done,
  input logic              pgm_timeout,
  input logic              clr_cmd,
  input logic              ready_o,
  input logic              tgt_vld,
  input logic [ADDR_W-1:0] tgt_addr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input ps_state_e         st
);

  AST_BUSY_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_o |-> tgt_vld); // R3

  AST_TARGET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_o |=> (ready_o || $stable(tgt_addr))); // R12

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R11

  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_BUSY && pgm_done && !pgm_timeout) |=> (ready_o && !tgt_vld)); // R7

  AST_TIMEOUT_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_BUSY && pgm_timeout) |=> (st == PS_FAIL)); // R8

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_FAIL && !clr_cmd) |=> (st == PS_FAIL && !ready_o)); // R9

endmodule

bind prog_status_rep prog_status_rep_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .pgm_done(pgm_done), .pgm_timeout(pgm_timeout),
  .clr_cmd(clr_cmd), .ready_o(ready_o), .tgt_vld(tgt_vld), .tgt_addr(tgt_addr),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .st(op_state)
);

// File: tb/prog_status_rep_tb_top.sv
module prog_status_rep_tb_top;

  localparam int AW = 4;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic pgm_start = 0, pgm_done = 0, pgm_timeout = 0, clr_cmd = 0;
  logic rd_valid = 0, rsp_ready = 1;
  logic [AW-1:0] rd_adr = '0;
  logic [DW-1:0] arr_rdata;
  logic [AW-1:0] tgt_addr;
  logic [DW-1:0] tgt_data, rsp_data;
  logic tgt_vld, ready_o, rd_ready, rsp_valid;

  logic [DW-1:0] mem [16];
  int checks = 0;
  int errors = 0;

  // reference model state
  int            m_state = 0;   // 0 ready, 1 busy, 2 failed
  logic          m_tog = 0, m_won = 0, m_vld = 0, m_rv = 0;
  logic [AW-1:0] m_la = '0, m_ta = '0;
  logic [DW-1:0] m_ld = '0, m_td = '0, m_rd = '0;

  always #2.5 clk = ~clk;

  assign arr_rdata = mem[rd_adr];

  prog_status_rep #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .pgm_start(pgm_start), .pgm_done(pgm_done),
    .pgm_timeout(pgm_timeout), .clr_cmd(clr_cmd),
    .tgt_addr(tgt_addr), .tgt_data(tgt_data), .tgt_vld(tgt_vld),
    .ready_o(ready_o), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .arr_rdata(arr_rdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] stat_of(input logic [DW-1:0] d, input logic t, input logic f);
    logic [DW-1:0] w;
    w = '0;
    w[7] = ~d[7];
    w[6] = t;
    w[5] = f;
    return w;
  endfunction

  // behavioural reference, evaluated at each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state <= 0; m_tog <= 0; m_won <= 0; m_vld <= 0; m_rv <= 0;
      m_la <= '0; m_ta <= '0; m_ld <= '0; m_td <= '0; m_rd <= '0;
    end else begin
      m_won <= !ce_n && !we_n;
      if (!ce_n && !we_n && !m_won) m_la <= bus_addr;
      if (!(!ce_n && !we_n) && m_won) m_ld <= bus_wdata;
      if (rd_valid && (!m_rv || rsp_ready)) begin
        m_rv <= 1;
        m_rd <= (m_state == 0) ? arr_rdata : stat_of(m_td, m_tog, m_state == 2);
        if (m_state != 0) m_tog <= !m_tog;
      end else if (rsp_ready) m_rv <= 0;
      if (m_state == 0 && pgm_start) begin
        m_state <= 1; m_ta <= m_la; m_td <= m_ld; m_vld <= 1; m_tog <= 0;
      end else if (m_state == 1 && pgm_timeout) begin
        m_state <= 2;
      end else if (m_state == 1 && pgm_done) begin
        m_state <= 0; m_vld <= 0; mem[m_ta] <= m_td;
      end else if (m_state == 2 && clr_cmd) begin
        m_state <= 0; m_vld <= 0;
      end
    end
  end

  // per-cycle comparison, 1 ns after the edge
  always @(posedge clk) begin
    #1;
    chk("R3 R7 R8 R9 ready_o", ready_o, m_state == 0);
    chk("R3 R10 tgt_vld", tgt_vld, m_vld);
    if (m_vld) begin
      chk("R1 R12 tgt_addr", tgt_addr, m_ta);
      chk("R2 tgt_data", tgt_data, m_td);
    end
    chk("R11 rsp_valid", rsp_valid, m_rv);
    if (m_rv) chk("R4 R5 R6 R7 R8 rsp_data", rsp_data, m_rd);
    chk("R11 rd_ready", rd_ready, !m_rv || rsp_ready);
  end

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); ce_n = 0; bus_wdata = ~d;
    @(negedge clk); we_n = 0; bus_addr = a;
    @(negedge clk); bus_addr = ~a; bus_wdata = d;
    @(negedge clk); we_n = 1;
    @(negedge clk); ce_n = 1; bus_wdata = ~d;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: pgm_start = 1;
      1: pgm_done = 1;
      2: pgm_timeout = 1;
      3: clr_cmd = 1;
      default: begin pgm_done = 1; pgm_timeout = 1; end
    endcase
    @(negedge clk);
    pgm_start = 0; pgm_done = 0; pgm_timeout = 0; clr_cmd = 0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk); rd_valid = 1; rd_adr = a;
    while (!rd_ready) @(negedge clk);
    @(posedge clk); #1 d = rsp_data;
    @(negedge clk); rd_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    for (int i = 0; i < 16; i++) mem[i] = 16'h0101 * i[15:0];
    repeat (3) @(negedge clk);
    chk("R10 reset ready", ready_o, 1);
    chk("R10 reset tgt_vld", tgt_vld, 0);
    chk("R10 reset rsp_valid", rsp_valid, 0);
    rst_n = 1;

    do_read(3, d); chk("R7 idle read", d, 16'h0303);

    // normal program with bit 7 set
    bus_write(5, 16'h3C80);
    pulse(0);
    chk("R1 target address", tgt_addr, 5);
    chk("R2 target data", tgt_data, 16'h3C80);
    chk("R3 busy", ready_o, 0);
    do_read(0, d); chk("R4 R5 R6 first busy read", d, 16'h0000);
    do_read(0, d); chk("R5 second busy read", d, 16'h0040);
    bus_write(9, 16'h1234);
    pulse(0);
    chk("R12 start ignored addr", tgt_addr, 5);
    do_read(0, d); chk("R12 toggle continues", d, 16'h0000);
    repeat (4) @(negedge clk);
    pulse(1);
    chk("R7 done ready", ready_o, 1);
    chk("R7 done released", tgt_vld, 0);
    do_read(5, d); chk("R7 true data after done", d, 16'h3C80);

    // program with bit 7 clear, then timeout
    bus_write(2, 16'h0011);
    pulse(0);
    do_read(0, d); chk("R4 inverted bit7", d, 16'h0080);
    do_read(0, d); chk("R5 toggle", d, 16'h00C0);
    pulse(3);
    chk("R9 clr ignored while busy", ready_o, 0);
    pulse(2);
    do_read(0, d); chk("R8 fail status", d, 16'h00A0);
    do_read(0, d); chk("R8 fail toggles", d, 16'h00E0);
    pulse(1);
    chk("R8 done ignored in fail", ready_o, 0);
    do_read(0, d); chk("R8 still failed", d, 16'h00A0);
    pulse(3);
    chk("R9 clr leaves fail", ready_o, 1);
    chk("R9 clr releases", tgt_vld, 0);
    do_read(2, d); chk("R9 array unchanged", d, 16'h0202);

    // back-pressure on the response channel
    bus_write(7, 16'h00FF);
    pulse(0);
    @(negedge clk); rsp_ready = 0; rd_valid = 1; rd_adr = 0;
    @(posedge clk); #1;
    chk("R11 first rsp", rsp_data, 16'h0000);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      chk("R11 held data", rsp_data, 16'h0000);
      chk("R11 stalled", rd_ready, 0);
    end
    @(negedge clk); rsp_ready = 1;
    @(posedge clk); #1;
    chk("R11 second rsp", rsp_data, 16'h0040);
    @(negedge clk); rd_valid = 0;

    // hardware reset mid-operation
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk);
    chk("R10 abort ready", ready_o, 1);
    chk("R10 abort released", tgt_vld, 0);
    rst_n = 1;
    do_read(7, d); chk("R10 read mode after abort", d, 16'h0707);

    // timeout wins over done in the same cycle
    bus_write(4, 16'h0080);
    pulse(0);
    pulse(4);
    chk("R8 timeout beats done", ready_o, 0);
    do_read(0, d); chk("R8 fail word", d, 16'h0020);
    pulse(3);
    chk("R9 cleared", ready_o, 1);

    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule